// File: doc/BRIEF.md
# Interrupt Enable, Pending Status and Software Reset Register

This block is one 16-bit control and status register that sits between a peripheral's event logic and its host. It holds a board-level interrupt enable, shows whether the event logic currently reports an interrupt condition, and raises an interrupt request only when both are true. The same register carries a software reset command. Writing that command produces a one-cycle pulse that clears the rest of the peripheral and leaves the interrupt enable as it was.

The host reaches the register over a plain synchronous strobe interface. The select input qualifies both strobes. A write takes effect on the clock edge where `sel_i` and `wr_en_i` are both high. A read strobe captures a snapshot that appears on `rdata_o` one cycle later. In every other cycle `rdata_o` is zero. The pending condition is an input, `pend_i`, and is produced outside the block.

Top module: `irq_ctl_reg`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, the enable is 0, and `irq_o`, `srst_o` and `rdata_o` are all 0.
- R2: A write (sel_i=1, wr_en_i=1) whose bit 8 is 0 loads bit 0 of `wdata_i` into the enable. The enable does not change in any cycle without a write.
- R3: A read returns the level of `pend_i` at the read edge in bit 1. Bit 1 of a write is ignored.
- R4: `irq_o` is combinationally `pend_i AND enable`, so it follows `pend_i` within the same cycle.
- R5: A write with bit 8 set drives `srst_o` high for exactly the one cycle after that write edge. `srst_o` is low in every other cycle.
- R6: A write with bit 8 set leaves the enable unchanged, whatever bit 0 of that write holds.
- R7: In read data, bits 15..9, bit 8 and bits 7..2 are always 0.
- R8: With `sel_i` low, the write and read strobes have no effect.
- R9: A read (sel_i=1, rd_en_i=1) presents {pending, enable} in bits 1..0 of `rdata_o` in the cycle after the read edge. The enable shown is the value before any write made at the same edge. `rdata_o` is all zero in the cycle after any edge without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| sel_i | input | 1 | Register select; qualifies both strobes |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data: bit 0 enable, bit 8 software reset |
| rdata_o | output | 16 | Read data, valid one cycle after a read strobe |
| pend_i | input | 1 | Pending interrupt condition from the event logic |
| irq_o | output | 1 | Interrupt request |
| srst_o | output | 1 | One-cycle reset pulse for the rest of the module |

## Verification
The only internal state is the enable flop. An error in that flop shows on `irq_o` in the same cycle as the next pending input, and on bit 0 of the next read one cycle after the read strobe. A mistake in the reset-command path shows as a missing, stretched or spurious `srst_o` pulse in the cycle after the write. It also shows as an enable that the reset write should not have changed, and the following read exposes that. A reference model compares every output in every cycle, so each of these errors is caught within one or two clocks.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    // Field positions inside the control word
    localparam int unsigned EN_POS   = 0;
    localparam int unsigned PEND_POS = 1;
    localparam int unsigned SRST_POS = 8;

    typedef struct packed {
        logic en;
    } en_state_t;

    typedef struct packed {
        logic pulse;
    } srst_state_t;
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_val,
    input  logic wr_srst,
    output logic en_o
);
    import irq_ctl_pkg::*;

    en_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_stb && !wr_srst) begin
            s_d.en = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o = s_q.en;

    // R2
    en_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(en_o));

    // R6
    srst_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_srst) |=> $stable(en_o));
endmodule

// File: rtl/irq_srst_pulse.sv
module irq_srst_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_srst,
    output logic pulse_o
);
    import irq_ctl_pkg::*;

    srst_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = wr_stb && wr_srst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse_o = s_q.pulse;

    // R5
    srst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_srst) |=> pulse_o);

    // R5
    srst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_srst) |=> !pulse_o);
endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port #(
    parameter int unsigned REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic             en_i,
    input  logic             pend_i,
    output logic [REG_W-1:0] rdata_o
);
    import irq_ctl_pkg::*;

    typedef struct packed {
        logic [REG_W-1:0] data;
    } rd_state_t;

    rd_state_t s_d, s_q;

    always_comb begin
        s_d      = '0;
        if (rd_stb) begin
            s_d.data[EN_POS]   = en_i;
            s_d.data[PEND_POS] = pend_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata_o = s_q.data;

    // R9
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (rdata_o == '0));

    // R3
    rd_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rdata_o[PEND_POS] == $past(pend_i)));

    // R7
    rd_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rdata_o) <= 2 && rdata_o[REG_W-1:2] == '0);
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg #(
    parameter int unsigned REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    input  logic             pend_i,
    output logic             irq_o,
    output logic             srst_o
);
    import irq_ctl_pkg::*;

    localparam int unsigned LOW_GAP = SRST_POS - PEND_POS - 1;

    logic wr_stb, rd_stb, en_q;
    logic unused_wbits;

    assign wr_stb = sel_i && wr_en_i;
    assign rd_stb = sel_i && rd_en_i;
    assign unused_wbits = ^{wdata_i[REG_W-1:SRST_POS+1], wdata_i[PEND_POS +: LOW_GAP+1]};

    irq_en_reg u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_val  (wdata_i[EN_POS]),
        .wr_srst (wdata_i[SRST_POS]),
        .en_o    (en_q)
    );

    irq_srst_pulse u_srst (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_srst (wdata_i[SRST_POS]),
        .pulse_o (srst_o)
    );

    irq_rd_port #(.REG_W(REG_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .en_i    (en_q),
        .pend_i  (pend_i),
        .rdata_o (rdata_o)
    );

    assign irq_o = pend_i && en_q;

    // R4
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend_i);

    // R8
    unsel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> (!srst_o && rdata_o == '0));
endmodule

// File: tb/irq_ctl_reg_tb_top.sv
module irq_ctl_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0, pend_i = 1'b0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        irq_o, srst_o;

    int checks = 0;
    int fails  = 0;

    // reference state
    int m_en = 0;
    int m_srst = 0;
    int m_rdata = 0;

    always #5 clk = ~clk;

    irq_ctl_reg dut_i (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .pend_i(pend_i), .irq_o(irq_o), .srst_o(srst_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // compare all outputs against the model (called mid-cycle)
    task automatic compare_all();
        chk("R4 irq", int'(irq_o), (m_en != 0 && pend_i) ? 1 : 0);
        chk("R5 srst", int'(srst_o), m_srst);
        chk("R9 rdata", int'(rdata_o), m_rdata);
        chk("R7 unused bits", int'(rdata_o & 16'hFFFC), 0);
    endtask

    // drive one cycle of stimulus, check, then advance model over the edge
    task automatic cyc(input logic s, input logic w, input logic r,
                       input logic [15:0] d, input logic p);
        bit wr, rd;
        sel_i = s; wr_en_i = w; rd_en_i = r; wdata_i = d; pend_i = p;
        #1;
        compare_all();
        wr = s && w;
        rd = s && r;
        m_rdata = rd ? ((p ? 2 : 0) | m_en) : 0;
        m_srst  = (wr && d[8]) ? 1 : 0;
        if (wr && !d[8]) m_en = d[0];
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #500000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1: reset state
        chk("R1 rdata", int'(rdata_o), 0);
        chk("R1 srst", int'(srst_o), 0);
        pend_i = 1'b1; #1;
        chk("R1 irq", int'(irq_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R9: read enable right after reset
        cyc(1, 0, 1, 16'h0000, 1);
        cyc(1, 0, 0, 16'h0000, 0);
        // R2: set enable, then R4 irq follows pend
        cyc(1, 1, 0, 16'h0001, 0);
        cyc(1, 0, 0, 16'h0000, 1);
        cyc(1, 0, 0, 16'h0000, 0);
        cyc(1, 0, 1, 16'h0000, 1);
        cyc(1, 0, 0, 16'h0000, 0);
        // R3: writing bit 1 ignored, enable cleared by bit0=0
        cyc(1, 1, 0, 16'h0002, 1);
        cyc(1, 0, 1, 16'h0000, 0);
        cyc(1, 0, 0, 16'h0000, 1);
        // R6: soft reset write with bit0=0 keeps enable set
        cyc(1, 1, 0, 16'h0001, 0);
        cyc(1, 1, 0, 16'h0100, 1);
        cyc(1, 0, 1, 16'h0000, 1);
        cyc(1, 0, 0, 16'h0000, 0);
        // R5: back-to-back reset writes, then reset write with bit0=1 while disabled
        cyc(1, 1, 0, 16'h0100, 0);
        cyc(1, 1, 0, 16'h0100, 0);
        cyc(1, 1, 0, 16'h0000, 0);
        cyc(1, 1, 0, 16'h0101, 1);
        cyc(1, 0, 1, 16'h0000, 1);
        cyc(1, 0, 0, 16'h0000, 0);
        // R8: unselected strobes do nothing
        cyc(0, 1, 1, 16'h0101, 1);
        cyc(0, 1, 1, 16'h0001, 1);
        cyc(1, 0, 1, 16'h0000, 1);
        // R9: read and write in the same cycle show the old enable
        cyc(1, 1, 1, 16'hFEFF, 1);
        cyc(1, 0, 1, 16'h0000, 1);
        cyc(1, 0, 0, 16'h0000, 1);
        // R7: all-ones write, reads stay within bits 1..0
        cyc(1, 1, 0, 16'hFFFF, 1);
        cyc(1, 0, 1, 16'hFFFF, 1);
        cyc(1, 0, 0, 16'h0000, 0);
        // mixed pattern sweep
        for (int i = 0; i < 200; i++) begin
            cyc(((i * 7) % 5) != 0, ((i * 3) % 4) == 1, ((i * 5) % 3) == 0,
                16'((i * 16'h1357) ^ (i << 8)), ((i * 11) % 7) < 3);
        end
        cyc(1, 0, 0, 16'h0000, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule